// File: doc/BRIEF.md
# USB host run/halt command controller

This block is the command and status core of a USB 2.0 host controller. Software writes one command word that carries a run bit, a controller-reset bit, a periodic-schedule enable and a two-bit frame-list size. The block turns these writes into a consistent run/halted state pair, a self-timed controller reset, and a microframe-driven frame index. From the frame index it derives the current frame-list index, and the list size picks which bits are used.

Once the run bit is cleared, the block waits for the transaction pipeline to report idle before it raises halted. If idle never arrives, a watchdog that counts microframe ticks forces the halt on the sixteenth tick and sets a timeout flag. A failed memory read also stops the controller and sets a host-error flag. The schedule walker reads a gating output that says whether periodic schedule processing may go ahead.

Top module: `hc_cmd_core`

## Requirements
- R1: After `rst_n` is released, `run_o`=0, `halted_o`=1, `fls_o`=00, `psched_en_o`=0, `frame_index_o`=0, and `host_err_o`, `halt_timeout_o` and `reset_busy_o` are all 0.
- R2: A command write with the run bit 1 while halted sets `run_o` and clears `halted_o` at the same clock edge. `run_o` and `halted_o` are never both 1.
- R3: A command write with the run bit 1 while halting (`run_o`=0, `halted_o`=0) is ignored, so `run_o` stays 0.
- R4: A command write with the run bit 0 while running clears `run_o` at that edge. `halted_o` rises at the first later edge at which `pipe_idle` is 1.
- R5: If `pipe_idle` stays 0 while halting, `halted_o` stays 0 through 15 microframe ticks. On the 16th tick counted from the run-clearing edge, `halted_o` and `halt_timeout_o` both go to 1.
- R6: `mem_rd_err` clears `run_o` and sets `host_err_o` at the next edge. The halt sequence then continues as in R4.
- R7: A command write with the reset bit 1 raises `reset_busy_o` and `xfer_abort_o` for exactly RST_CYCLES clocks, counted from the write edge. During that time every register holds its R1 value. After it, `reset_busy_o` clears by itself.
- R8: Command writes while `reset_busy_o` is 1 have no effect, including writes whose reset bit is 0.
- R9: Frame-list size encodings are 00 for 1024 entries, 01 for 512 and 10 for 256. The field is written only when `cap_prog_fls` is 1. A write of the reserved code 11 keeps the previous value.
- R10: `frame_index_o` (14 bits) rises by 1 on each `uframe_tick` while running (`run_o`=1, `halted_o`=0) and wraps modulo 16384. It holds at all other times.
- R11: `list_index_o` is frame_index[12:3] for size 00, frame_index[11:3] for 01 and frame_index[10:3] for 10, zero-extended to 10 bits.
- R12: `psched_en_o` takes the command's periodic-enable bit on each accepted write. `psched_go_o` is 1 exactly when `psched_en_o`=1 and the controller is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_run | input | 1 | Run bit of the command |
| cmd_reset | input | 1 | Controller-reset bit of the command |
| cmd_psched | input | 1 | Periodic schedule enable bit of the command |
| cmd_fls | input | 2 | Frame-list size code of the command |
| cap_prog_fls | input | 1 | 1 makes the list size programmable |
| uframe_tick | input | 1 | One-clock pulse per microframe |
| pipe_idle | input | 1 | 1 when no transaction is in flight |
| mem_rd_err | input | 1 | Memory read finished with an error status |
| run_o | output | 1 | Run state |
| halted_o | output | 1 | Halted status |
| reset_busy_o | output | 1 | Controller reset in progress |
| xfer_abort_o | output | 1 | Terminate any transaction in progress |
| psched_en_o | output | 1 | Periodic schedule enable |
| fls_o | output | 2 | Current frame-list size code |
| frame_index_o | output | 14 | Microframe index |
| list_index_o | output | 10 | Current frame-list index |
| host_err_o | output | 1 | Memory read error seen |
| halt_timeout_o | output | 1 | Halt was forced by the tick watchdog |
| psched_go_o | output | 1 | Periodic schedule processing allowed |

## Verification
Command effects on `run_o`, `halted_o`, `fls_o`, `psched_en_o`, `reset_busy_o` and the flags are all due one edge after the write. The bench drives each write on a falling edge and samples on the next falling edge. Halt completion is due one edge after `pipe_idle` is seen in the halting state, and the timeout halt is due at the edge of the 16th tick. The bench steps ticks one clock at a time and checks both just before and just after that edge. The frame and list indices follow the tick of the preceding edge. A bench model recomputes them each cycle, using shifts and modulo on its own tick count, and the reset window is measured by counting sampled busy cycles.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;
  localparam int FI_W = 14;
  localparam int LI_W = 10;

  typedef enum logic [1:0] {
    FLS_1024 = 2'b00,
    FLS_512  = 2'b01,
    FLS_256  = 2'b10,
    FLS_RSVD = 2'b11
  } fls_e;

  // A size code may be stored only if it is not the reserved one.
  function automatic logic fls_storable(input logic [1:0] code);
    return code != FLS_RSVD;
  endfunction

  // Pick the frame-list index bits out of the microframe index.
  function automatic logic [LI_W-1:0] list_idx(input logic [FI_W-1:0] fi,
                                               input logic [1:0] code);
    logic [LI_W-1:0] r;
    case (code)
      FLS_512: r = {1'b0, fi[11:3]};
      FLS_256: r = {2'b00, fi[10:3]};
      default: r = fi[12:3];
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hc_reset_seq.sv
module hc_reset_seq #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic start_o,
  output logic busy_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign start_o = req && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (start_o) begin
      busy_o <= 1'b1;
      cnt    <= LAST;
    end else if (busy_o) begin
      if (cnt == '0) busy_o <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/hc_run_ctrl.sv
module hc_run_ctrl #(
  parameter int HALT_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_req,
  input  logic stop_req,
  input  logic mem_err,
  input  logic tick,
  input  logic pipe_idle,
  output logic run_o,
  output logic halted_o,
  output logic timeout_o
);
  localparam int TW = $clog2(HALT_TICKS + 1);
  localparam logic [TW-1:0] TLAST = TW'(HALT_TICKS - 1);

  logic [TW-1:0] tcnt;
  logic          halting;
  logic          tick_limit;

  assign halting    = !run_o && !halted_o;
  assign tick_limit = tick && (tcnt == TLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o     <= 1'b0;
      halted_o  <= 1'b1;
      timeout_o <= 1'b0;
      tcnt      <= '0;
    end else if (clr) begin
      run_o     <= 1'b0;
      halted_o  <= 1'b1;
      timeout_o <= 1'b0;
      tcnt      <= '0;
    end else if (run_o) begin
      if (mem_err || stop_req) begin
        run_o <= 1'b0;
        tcnt  <= '0;
      end
    end else if (halting) begin
      if (pipe_idle) begin
        halted_o <= 1'b1;
      end else if (tick_limit) begin
        halted_o  <= 1'b1;
        timeout_o <= 1'b1;
      end else if (tick) begin
        tcnt <= tcnt + 1'b1;
      end
    end else if (set_req && !mem_err) begin
      run_o    <= 1'b1;
      halted_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hc_frame_ctr.sv
module hc_frame_ctr
  import hc_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  input  logic [1:0]      fls,
  output logic [FI_W-1:0] fi_o,
  output logic [LI_W-1:0] li_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   fi_o <= '0;
    else if (clr) fi_o <= '0;
    else if (adv) fi_o <= fi_o + 1'b1;
  end

  assign li_o = list_idx(fi_o, fls);
endmodule

// File: rtl/hc_cmd_core.sv
module hc_cmd_core
  import hc_cmd_pkg::*;
#(
  parameter int RST_CYCLES = 8,
  parameter int HALT_TICKS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic            cmd_run,
  input  logic            cmd_reset,
  input  logic            cmd_psched,
  input  logic [1:0]      cmd_fls,
  input  logic            cap_prog_fls,
  input  logic            uframe_tick,
  input  logic            pipe_idle,
  input  logic            mem_rd_err,
  output logic            run_o,
  output logic            halted_o,
  output logic            reset_busy_o,
  output logic            xfer_abort_o,
  output logic            psched_en_o,
  output logic [1:0]      fls_o,
  output logic [FI_W-1:0] frame_index_o,
  output logic [LI_W-1:0] list_index_o,
  output logic            host_err_o,
  output logic            halt_timeout_o,
  output logic            psched_go_o
);
  // Named internal events
  logic rst_start;
  logic clr;
  logic sw_wr;
  logic running;
  logic frame_adv;

  hc_reset_seq #(.CYCLES(RST_CYCLES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (cmd_wr && cmd_reset),
    .start_o (rst_start),
    .busy_o  (reset_busy_o)
  );

  assign clr          = rst_start || reset_busy_o;
  assign xfer_abort_o = clr;
  assign sw_wr        = cmd_wr && !clr;

  hc_run_ctrl #(.HALT_TICKS(HALT_TICKS)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .set_req   (sw_wr && cmd_run),
    .stop_req  (sw_wr && !cmd_run),
    .mem_err   (mem_rd_err),
    .tick      (uframe_tick),
    .pipe_idle (pipe_idle),
    .run_o     (run_o),
    .halted_o  (halted_o),
    .timeout_o (halt_timeout_o)
  );

  assign running   = run_o && !halted_o;
  assign frame_adv = running && uframe_tick;

  hc_frame_ctr u_frm (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .adv   (frame_adv),
    .fls   (fls_o),
    .fi_o  (frame_index_o),
    .li_o  (list_index_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psched_en_o <= 1'b0;
      fls_o       <= FLS_1024;
      host_err_o  <= 1'b0;
    end else if (clr) begin
      psched_en_o <= 1'b0;
      fls_o       <= FLS_1024;
      host_err_o  <= 1'b0;
    end else begin
      if (sw_wr) psched_en_o <= cmd_psched;
      if (sw_wr && cap_prog_fls && fls_storable(cmd_fls)) fls_o <= cmd_fls;
      if (mem_rd_err) host_err_o <= 1'b1;
    end
  end

  assign psched_go_o = psched_en_o && running;
endmodule

// File: rtl/hc_cmd_core_chk.sv
module hc_cmd_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic        cmd_reset,
  input logic        uframe_tick,
  input logic        mem_rd_err,
  input logic        run_o,
  input logic        halted_o,
  input logic        reset_busy_o,
  input logic [1:0]  fls_o,
  input logic [13:0] frame_index_o,
  input logic        host_err_o
);
  logic       halting;
  logic [4:0] hcnt;

  assign halting = !run_o && !halted_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hcnt <= '0;
    else if (!halting)       hcnt <= '0;
    else if (uframe_tick)    hcnt <= hcnt + 1'b1;
  end

  a_r2_never_run_and_halted: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_o && halted_o));

  a_r3_halting_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    halting |=> !run_o);

  a_r5_halt_within_bound: assert property (@(posedge clk) disable iff (!rst_n)
    halting |-> (hcnt < 5'd16));

  a_r6_error_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_err && run_o && !(cmd_wr && cmd_reset)) |=> (!run_o && host_err_o));

  a_r7_busy_holds_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    reset_busy_o |-> (!run_o && halted_o && frame_index_o == 14'd0 && fls_o == 2'b00));

  a_r9_no_reserved_size: assert property (@(posedge clk) disable iff (!rst_n)
    fls_o != 2'b11);

  a_r10_frame_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run_o && !halted_o && uframe_tick) && !(cmd_wr && cmd_reset)) |=> $stable(frame_index_o));
endmodule

bind hc_cmd_core hc_cmd_core_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_wr        (cmd_wr),
  .cmd_reset     (cmd_reset),
  .uframe_tick   (uframe_tick),
  .mem_rd_err    (mem_rd_err),
  .run_o         (run_o),
  .halted_o      (halted_o),
  .reset_busy_o  (reset_busy_o),
  .fls_o         (fls_o),
  .frame_index_o (frame_index_o),
  .host_err_o    (host_err_o)
);

// File: tb/test_hc_cmd_core.sv
module test_hc_cmd_core;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0, cmd_run = 1'b0, cmd_reset = 1'b0, cmd_psched = 1'b0;
  logic [1:0]  cmd_fls = 2'b00;
  logic        cap_prog_fls = 1'b0, uframe_tick = 1'b0, pipe_idle = 1'b0, mem_rd_err = 1'b0;
  logic        run_o, halted_o, reset_busy_o, xfer_abort_o, psched_en_o;
  logic [1:0]  fls_o;
  logic [13:0] frame_index_o;
  logic [9:0]  list_index_o;
  logic        host_err_o, halt_timeout_o, psched_go_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  hc_cmd_core #(.RST_CYCLES(RST_CYC), .HALT_TICKS(16)) i_hc_cmd_core (
    .clk, .rst_n, .cmd_wr, .cmd_run, .cmd_reset, .cmd_psched, .cmd_fls,
    .cap_prog_fls, .uframe_tick, .pipe_idle, .mem_rd_err,
    .run_o, .halted_o, .reset_busy_o, .xfer_abort_o, .psched_en_o, .fls_o,
    .frame_index_o, .list_index_o, .host_err_o, .halt_timeout_o, .psched_go_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_list(input int fi, input int code);
    return (fi >> 3) % (1024 >> code);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic r, input logic rs, input logic ps, input logic [1:0] f);
    cmd_wr = 1'b1; cmd_run = r; cmd_reset = rs; cmd_psched = ps; cmd_fls = f;
    step();
    cmd_wr = 1'b0; cmd_reset = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        tests++; fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int efi;
    int efls;
    int cnt;
    void'($urandom(32'd4711));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 run", run_o, 0);
    chk("R1 halted", halted_o, 1);
    chk("R1 fls", fls_o, 0);
    chk("R1 psched", psched_en_o, 0);
    chk("R1 frame", frame_index_o, 0);
    chk("R1 flags", {host_err_o, halt_timeout_o, reset_busy_o}, 0);

    // R9 size programming
    wr(1'b0, 1'b0, 1'b0, 2'b01);
    chk("R9 no cap", fls_o, 0);
    cap_prog_fls = 1'b1;
    wr(1'b0, 1'b0, 1'b0, 2'b01);
    chk("R9 write 01", fls_o, 1);
    wr(1'b0, 1'b0, 1'b0, 2'b11);
    chk("R9 reserved kept", fls_o, 1);
    wr(1'b0, 1'b0, 1'b0, 2'b10);
    chk("R9 write 10", fls_o, 2);
    wr(1'b0, 1'b0, 1'b0, 2'b00);
    chk("R9 write 00", fls_o, 0);

    // R2 start, R12 gating
    wr(1'b1, 1'b0, 1'b1, 2'b00);
    chk("R2 run set", run_o, 1);
    chk("R2 halted cleared", halted_o, 0);
    chk("R12 go", psched_go_o, 1);

    // R10 R11 R12 random phase
    efi = 0; efls = 0;
    for (int i = 0; i < 400; i++) begin
      logic t;
      logic w;
      logic ps;
      logic [1:0] f;
      t = 1'($urandom % 2);
      w = ($urandom % 8) == 0;
      ps = 1'($urandom % 2);
      f = 2'($urandom % 4);
      uframe_tick = t;
      if (w) begin
        cmd_wr = 1'b1; cmd_run = 1'b1; cmd_psched = ps; cmd_fls = f;
      end
      step();
      cmd_wr = 1'b0;
      if (t) efi = (efi + 1) % 16384;
      if (w && f != 2'b11) efls = f;
      chk("R10 frame", frame_index_o, efi);
      chk("R11 list", list_index_o, exp_list(efi, efls));
      chk("R12 go", psched_go_o, psched_en_o);
      if (w) chk("R12 psched", psched_en_o, ps);
    end
    // R10 wrap
    uframe_tick = 1'b1;
    repeat (16384 + 5) step();
    uframe_tick = 1'b0;
    efi = (efi + 5) % 16384;
    chk("R10 wrap", frame_index_o, efi);

    // R4 halt with idle pipeline
    pipe_idle = 1'b1;
    wr(1'b0, 1'b0, 1'b1, 2'b00);
    chk("R4 run cleared", run_o, 0);
    chk("R4 not yet halted", halted_o, 0);
    chk("R12 go off", psched_go_o, 0);
    step();
    chk("R4 halted", halted_o, 1);
    chk("R4 no timeout", halt_timeout_o, 0);
    efi = frame_index_o;
    uframe_tick = 1'b1;
    repeat (5) step();
    uframe_tick = 1'b0;
    chk("R10 held while halted", frame_index_o, efi);

    // R3 and R5
    pipe_idle = 1'b0;
    wr(1'b1, 1'b0, 1'b0, 2'b00);
    chk("R2 restart", run_o, 1);
    wr(1'b0, 1'b0, 1'b0, 2'b00);
    wr(1'b1, 1'b0, 1'b0, 2'b00);
    chk("R3 ignored run", run_o, 0);
    chk("R3 still halting", halted_o, 0);
    uframe_tick = 1'b1;
    repeat (15) step();
    chk("R5 halted before 16", halted_o, 0);
    step();
    uframe_tick = 1'b0;
    chk("R5 halted at 16", halted_o, 1);
    chk("R5 timeout flag", halt_timeout_o, 1);

    // R6 memory error
    wr(1'b1, 1'b0, 1'b0, 2'b00);
    mem_rd_err = 1'b1;
    step();
    mem_rd_err = 1'b0;
    chk("R6 run cleared", run_o, 0);
    chk("R6 host err", host_err_o, 1);
    chk("R6 halting", halted_o, 0);
    pipe_idle = 1'b1;
    step();
    chk("R6 halted", halted_o, 1);

    // R7 R8 reset sequence
    wr(1'b0, 1'b0, 1'b1, 2'b10);
    chk("R7 pre fls", fls_o, 2);
    wr(1'b0, 1'b1, 1'b0, 2'b00);
    cnt = 1;
    chk("R7 busy", reset_busy_o, 1);
    chk("R7 abort", xfer_abort_o, 1);
    chk("R7 fls default", fls_o, 0);
    chk("R7 psched default", psched_en_o, 0);
    chk("R7 flags default", {host_err_o, halt_timeout_o}, 0);
    wr(1'b1, 1'b0, 1'b1, 2'b01);
    if (reset_busy_o) cnt++;
    chk("R8 busy kept", reset_busy_o, 1);
    chk("R8 run ignored", run_o, 0);
    chk("R8 fls ignored", fls_o, 0);
    chk("R8 psched ignored", psched_en_o, 0);
    for (int i = 0; i < 40 && reset_busy_o; i++) begin
      step();
      if (reset_busy_o) cnt++;
    end
    chk("R7 busy length", cnt, RST_CYC);
    chk("R7 self clear", reset_busy_o, 0);
    wr(1'b1, 1'b0, 1'b0, 2'b00);
    chk("R7 usable after", run_o, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule